// File: doc/BRIEF.md
# System register access permission checker

This block decides what happens to a 32-bit coprocessor move, read or write, that targets one hypervisor-level trap-control register. It first compares the move's five encoding fields with the register's encoding. It then applies an ordered decision chain for the current exception level and picks one outcome:

- the access is performed;
- the instruction is undefined;
- the access traps to the hypervisor level, in its 64-bit form or its 32-bit form;
- the access traps to the secure monitor level.

The inputs to the decision chain are:

- whether the hypervisor is enabled, and its register width;
- the hypervisor's system-register trap bit;
- whether a secure monitor is present, and its width;
- the monitor's control-access trap bit;
- a debug-undefined condition, together with its priority flag;
- the non-secure bit.

The decision is combinational. It is captured in a single result stage, so the outcome appears one cycle after the request along with a valid strobe. The stage also returns the read data, or drives a write enable and write data towards the register storage. The storage itself is outside this block: its current value comes in on a port.

Top module: `sysreg_access_checker`

## Requirements
- R1: A request is recognised only when coproc_i = 15, opc1_i = 4, crn_i = 1, crm_i = 1 and opc2_i = 2, for both read and write. A request whose encoding differs in any field gives res_valid_o = 0 and all outcome, syndrome, target, data and write-enable outputs 0 in the following cycle.
- R2: A recognised request at level 0 (cur_el_i = 0) gives undef_o, with target_el_o = 1.
- R3: At level 1, when hyp_enabled_i = 1 and hyp_t1_i = 1, the request traps to the hypervisor with syndrome_o = 0x03 and target_el_o = 2. It asserts trap_hyp64_o when hyp_is_64_i = 1 and trap_hyp32_o when hyp_is_64_i = 0.
- R4: At level 1, when the hypervisor is disabled or hyp_t1_i = 0, the request gives undef_o with target_el_o = 1.
- R5: At level 2, the monitor trap is active when mon_present_i = 1, mon_is_64_i = 1 and mon_tcpac_i = 1. When it is active and dbg_undef_prio_i = 1, the request gives undef_o with target_el_o = 2, whatever dbg_undef_i is.
- R6: At level 2, with the monitor trap active and dbg_undef_prio_i = 0:
  - dbg_undef_i = 1 gives undef_o with target_el_o = 2;
  - dbg_undef_i = 0 gives trap_mon_o with syndrome_o = 0x03 and target_el_o = 3.
- R7: At level 2 with the monitor trap inactive, the access is performed (do_access_o = 1, target_el_o = 2). This includes a 32-bit monitor that has its trap bit set.
- R8: At level 3, the request gives undef_o (target_el_o = 3) when ns_bit_i = 0. It is performed (do_access_o = 1, target_el_o = 3) when ns_bit_i = 1.
- R9: Each recognised request gives, exactly one cycle later:
  - res_valid_o = 1 for one cycle;
  - exactly one of do_access_o, undef_o, trap_hyp64_o, trap_hyp32_o, trap_mon_o;
  - syndrome_o = 0 for undef and for a performed access.
- R10: reg_we_o = 1 only for a performed write, with reg_wdata_o = the request's wdata_i. A performed read gives rdata_o = reg_value_i as sampled with the request. rdata_o is 0 for every other result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Move request present |
| req_write_i | input | 1 | 1 = write move, 0 = read move |
| coproc_i | input | 4 | Coprocessor number field |
| opc1_i | input | 3 | First opcode field |
| crn_i | input | 4 | Primary register field |
| crm_i | input | 4 | Secondary register field |
| opc2_i | input | 3 | Second opcode field |
| cur_el_i | input | 2 | Current exception level |
| wdata_i | input | 32 | Write data of the move |
| hyp_enabled_i | input | 1 | Hypervisor level enabled |
| hyp_is_64_i | input | 1 | Hypervisor uses 64-bit registers |
| hyp_t1_i | input | 1 | Hypervisor system-register trap bit |
| mon_present_i | input | 1 | Secure monitor level implemented |
| mon_is_64_i | input | 1 | Secure monitor uses 64-bit registers |
| mon_tcpac_i | input | 1 | Monitor control-access trap bit |
| dbg_undef_i | input | 1 | Debug-undefined condition |
| dbg_undef_prio_i | input | 1 | Debug-undefined priority flag |
| ns_bit_i | input | 1 | Non-secure bit |
| reg_value_i | input | 32 | Current register contents |
| res_valid_o | output | 1 | Result strobe, one cycle after a recognised request |
| do_access_o | output | 1 | Access performed |
| undef_o | output | 1 | Undefined instruction |
| trap_hyp64_o | output | 1 | Trap to hypervisor, 64-bit form |
| trap_hyp32_o | output | 1 | Trap to hypervisor, 32-bit form |
| trap_mon_o | output | 1 | Trap to secure monitor |
| syndrome_o | output | 6 | Syndrome class of a trap |
| target_el_o | output | 2 | Level that handles the result |
| rdata_o | output | 32 | Read data of a performed read |
| reg_we_o | output | 1 | Write enable to register storage |
| reg_wdata_o | output | 32 | Write data to register storage |

## Verification
The only state in this block is the result stage. A stage that captures the wrong outcome code shows up in the next cycle, either as the wrong outcome line or as two lines at once next to res_valid_o. A stage that holds a stale outcome shows up as outcome lines still high one cycle after a request, with no new request behind them. A wrong branch order in the decision chain is only visible under particular input combinations, for example the priority flag taking effect while the monitor is 32-bit. For that reason each branch is driven on its own and also next to its neighbours, and the bench reads the result one cycle after each request.

// File: rtl/sysreg_chk_pkg.sv
package sysreg_chk_pkg;
  localparam int EL_W = 2;
  localparam int EC_W = 6;
  localparam logic [EC_W-1:0] EC_SYSACC = 6'h03;
  localparam int N_OUT = 5;

  typedef enum logic [2:0] {
    OUT_NONE   = 3'd0,
    OUT_ACCESS = 3'd1,
    OUT_UNDEF  = 3'd2,
    OUT_HYP64  = 3'd3,
    OUT_HYP32  = 3'd4,
    OUT_MON    = 3'd5
  } outcome_e;

  typedef struct packed {
    outcome_e            kind;
    logic [EC_W-1:0]     ec;
    logic [EL_W-1:0]     tgt;
  } verdict_t;
endpackage

// File: rtl/sysreg_enc_match.sv
module sysreg_enc_match #(
  parameter int          CP_W    = 4,
  parameter int          OP1_W   = 3,
  parameter int          CR_W    = 4,
  parameter int          OP2_W   = 3,
  parameter logic [3:0]  ENC_CP  = 4'd15,
  parameter logic [2:0]  ENC_OP1 = 3'd4,
  parameter logic [3:0]  ENC_CRN = 4'd1,
  parameter logic [3:0]  ENC_CRM = 4'd1,
  parameter logic [2:0]  ENC_OP2 = 3'd2
) (
  input  logic [CP_W-1:0]  coproc_i,
  input  logic [OP1_W-1:0] opc1_i,
  input  logic [CR_W-1:0]  crn_i,
  input  logic [CR_W-1:0]  crm_i,
  input  logic [OP2_W-1:0] opc2_i,
  output logic             hit_o
);
  localparam int N_FLD = 5;
  logic [N_FLD-1:0] fld_ok;

  always_comb begin
    fld_ok[0] = (coproc_i == CP_W'(ENC_CP));
    fld_ok[1] = (opc1_i   == OP1_W'(ENC_OP1));
    fld_ok[2] = (crn_i    == CR_W'(ENC_CRN));
    fld_ok[3] = (crm_i    == CR_W'(ENC_CRM));
    fld_ok[4] = (opc2_i   == OP2_W'(ENC_OP2));
  end

  assign hit_o = &fld_ok;
endmodule

// File: rtl/sysreg_access_decide.sv
module sysreg_access_decide
  import sysreg_chk_pkg::*;
(
  input  logic [EL_W-1:0] cur_el_i,
  input  logic            hyp_enabled_i,
  input  logic            hyp_is_64_i,
  input  logic            hyp_t1_i,
  input  logic            mon_present_i,
  input  logic            mon_is_64_i,
  input  logic            mon_tcpac_i,
  input  logic            dbg_undef_i,
  input  logic            dbg_undef_prio_i,
  input  logic            ns_bit_i,
  output verdict_t        verdict_o
);
  logic mon_trap;
  assign mon_trap = mon_present_i & mon_is_64_i & mon_tcpac_i;

  always_comb begin
    verdict_o = '{kind: OUT_UNDEF, ec: '0, tgt: cur_el_i};
    unique case (cur_el_i)
      2'd0: verdict_o.tgt = 2'd1;
      2'd1: begin
        if (hyp_enabled_i && hyp_t1_i) begin
          verdict_o.kind = hyp_is_64_i ? OUT_HYP64 : OUT_HYP32;
          verdict_o.ec   = EC_SYSACC;
          verdict_o.tgt  = 2'd2;
        end
      end
      2'd2: begin
        // priority flag is checked ahead of the monitor trap itself
        if (mon_trap && dbg_undef_prio_i) begin
          verdict_o.kind = OUT_UNDEF;
        end else if (mon_trap) begin
          if (!dbg_undef_i) begin
            verdict_o.kind = OUT_MON;
            verdict_o.ec   = EC_SYSACC;
            verdict_o.tgt  = 2'd3;
          end
        end else begin
          verdict_o.kind = OUT_ACCESS;
        end
      end
      default: begin
        if (ns_bit_i) verdict_o.kind = OUT_ACCESS;
      end
    endcase
  end
endmodule

// File: rtl/sysreg_result_stage.sv
module sysreg_result_stage
  import sysreg_chk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fire_i,
  input  logic                write_i,
  input  verdict_t            verdict_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W-1:0]   reg_value_i,
  output logic                res_valid_o,
  output logic [N_OUT-1:0]    outcome_oh_o,
  output logic [EC_W-1:0]     syndrome_o,
  output logic [EL_W-1:0]     target_el_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                reg_we_o,
  output logic [DATA_W-1:0]   reg_wdata_o
);
  logic [N_OUT-1:0] oh_d;
  logic             acc_d;

  // bit i of the one-hot vector is outcome code i+1
  for (genvar i = 0; i < N_OUT; i++) begin : g_oh
    assign oh_d[i] = fire_i && (verdict_i.kind == outcome_e'(i + 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) outcome_oh_o[i] <= 1'b0;
      else         outcome_oh_o[i] <= oh_d[i];
    end
  end

  assign acc_d = oh_d[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      syndrome_o  <= '0;
      target_el_o <= '0;
      rdata_o     <= '0;
      reg_we_o    <= 1'b0;
      reg_wdata_o <= '0;
    end else begin
      res_valid_o <= fire_i;
      syndrome_o  <= fire_i ? verdict_i.ec  : '0;
      target_el_o <= fire_i ? verdict_i.tgt : '0;
      rdata_o     <= (acc_d && !write_i) ? reg_value_i : '0;
      reg_we_o    <= acc_d && write_i;
      reg_wdata_o <= (acc_d && write_i) ? wdata_i : '0;
    end
  end
endmodule

// File: rtl/sysreg_access_checker.sv
module sysreg_access_checker
  import sysreg_chk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [3:0]        coproc_i,
  input  logic [2:0]        opc1_i,
  input  logic [3:0]        crn_i,
  input  logic [3:0]        crm_i,
  input  logic [2:0]        opc2_i,
  input  logic [1:0]        cur_el_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hyp_enabled_i,
  input  logic              hyp_is_64_i,
  input  logic              hyp_t1_i,
  input  logic              mon_present_i,
  input  logic              mon_is_64_i,
  input  logic              mon_tcpac_i,
  input  logic              dbg_undef_i,
  input  logic              dbg_undef_prio_i,
  input  logic              ns_bit_i,
  input  logic [DATA_W-1:0] reg_value_i,
  output logic              res_valid_o,
  output logic              do_access_o,
  output logic              undef_o,
  output logic              trap_hyp64_o,
  output logic              trap_hyp32_o,
  output logic              trap_mon_o,
  output logic [5:0]        syndrome_o,
  output logic [1:0]        target_el_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              reg_we_o,
  output logic [DATA_W-1:0] reg_wdata_o
);
  logic             enc_hit;
  verdict_t         verdict;
  logic [N_OUT-1:0] oh_q;

  sysreg_enc_match u_match (
    .coproc_i (coproc_i),
    .opc1_i   (opc1_i),
    .crn_i    (crn_i),
    .crm_i    (crm_i),
    .opc2_i   (opc2_i),
    .hit_o    (enc_hit)
  );

  sysreg_access_decide u_decide (
    .cur_el_i         (cur_el_i),
    .hyp_enabled_i    (hyp_enabled_i),
    .hyp_is_64_i      (hyp_is_64_i),
    .hyp_t1_i         (hyp_t1_i),
    .mon_present_i    (mon_present_i),
    .mon_is_64_i      (mon_is_64_i),
    .mon_tcpac_i      (mon_tcpac_i),
    .dbg_undef_i      (dbg_undef_i),
    .dbg_undef_prio_i (dbg_undef_prio_i),
    .ns_bit_i         (ns_bit_i),
    .verdict_o        (verdict)
  );

  sysreg_result_stage #(.DATA_W(DATA_W)) u_stage (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fire_i       (req_valid_i && enc_hit),
    .write_i      (req_write_i),
    .verdict_i    (verdict),
    .wdata_i      (wdata_i),
    .reg_value_i  (reg_value_i),
    .res_valid_o  (res_valid_o),
    .outcome_oh_o (oh_q),
    .syndrome_o   (syndrome_o),
    .target_el_o  (target_el_o),
    .rdata_o      (rdata_o),
    .reg_we_o     (reg_we_o),
    .reg_wdata_o  (reg_wdata_o)
  );

  assign do_access_o  = oh_q[0];
  assign undef_o      = oh_q[1];
  assign trap_hyp64_o = oh_q[2];
  assign trap_hyp32_o = oh_q[3];
  assign trap_mon_o   = oh_q[4];
endmodule

// File: rtl/sysreg_access_checker_sva.sv
module sysreg_access_checker_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_write_i,
  input logic [3:0] coproc_i,
  input logic [2:0] opc1_i,
  input logic [3:0] crn_i,
  input logic [3:0] crm_i,
  input logic [2:0] opc2_i,
  input logic [1:0] cur_el_i,
  input logic       ns_bit_i,
  input logic       res_valid_o,
  input logic       do_access_o,
  input logic       undef_o,
  input logic       trap_hyp64_o,
  input logic       trap_hyp32_o,
  input logic       trap_mon_o,
  input logic [5:0] syndrome_o,
  input logic [1:0] target_el_o,
  input logic       reg_we_o
);
  logic       req_hit;
  logic [4:0] outs;
  assign req_hit = req_valid_i && coproc_i == 4'd15 && opc1_i == 3'd4 &&
                   crn_i == 4'd1 && crm_i == 4'd1 && opc2_i == 3'd2;
  assign outs = {do_access_o, undef_o, trap_hyp64_o, trap_hyp32_o, trap_mon_o};

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $onehot(outs)); // R9
  AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (outs == 5'b0 && !reg_we_o)); // R1
  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_hit |=> res_valid_o); // R9
  AST_EL0_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_hit && cur_el_i == 2'd0) |=> (undef_o && target_el_o == 2'd1)); // R2
  AST_TRAP_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_hyp64_o || trap_hyp32_o || trap_mon_o) |-> syndrome_o == 6'h03); // R3
  AST_MON_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_mon_o |-> target_el_o == 2'd3); // R6
  AST_SECURE_EL3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_hit && cur_el_i == 2'd3 && !ns_bit_i) |=> undef_o); // R8
  AST_WE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (do_access_o && $past(req_write_i))); // R10
endmodule

bind sysreg_access_checker sysreg_access_checker_sva u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_write_i  (req_write_i),
  .coproc_i     (coproc_i),
  .opc1_i       (opc1_i),
  .crn_i        (crn_i),
  .crm_i        (crm_i),
  .opc2_i       (opc2_i),
  .cur_el_i     (cur_el_i),
  .ns_bit_i     (ns_bit_i),
  .res_valid_o  (res_valid_o),
  .do_access_o  (do_access_o),
  .undef_o      (undef_o),
  .trap_hyp64_o (trap_hyp64_o),
  .trap_hyp32_o (trap_hyp32_o),
  .trap_mon_o   (trap_mon_o),
  .syndrome_o   (syndrome_o),
  .target_el_o  (target_el_o),
  .reg_we_o     (reg_we_o)
);

// File: tb/sysreg_access_checker_test.sv
module sysreg_access_checker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  coproc = 4'd15, crn = 4'd1, crm = 4'd1;
  logic [2:0]  opc1 = 3'd4, opc2 = 3'd2;
  logic [1:0]  cur_el = 2'd0;
  logic [31:0] wdata = '0, reg_value = 32'hA5C3_0F1E;
  logic hyp_en = 0, hyp_64 = 0, hyp_t1 = 0, mon_pr = 0, mon_64 = 0, mon_tc = 0;
  logic dbg_u = 0, dbg_p = 0, ns = 0;
  logic res_valid, do_acc, undef, th64, th32, tmon, we;
  logic [5:0]  synd;
  logic [1:0]  tgt;
  logic [31:0] rdata, rwdata;

  int n_checks = 0;
  int n_fail   = 0;

  localparam logic [4:0] X_ACC = 5'b10000, X_UND = 5'b01000, X_H64 = 5'b00100,
                         X_H32 = 5'b00010, X_MON = 5'b00001;

  always #10 clk = ~clk;

  sysreg_access_checker uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .coproc_i(coproc), .opc1_i(opc1), .crn_i(crn), .crm_i(crm), .opc2_i(opc2),
    .cur_el_i(cur_el), .wdata_i(wdata), .hyp_enabled_i(hyp_en), .hyp_is_64_i(hyp_64),
    .hyp_t1_i(hyp_t1), .mon_present_i(mon_pr), .mon_is_64_i(mon_64),
    .mon_tcpac_i(mon_tc), .dbg_undef_i(dbg_u), .dbg_undef_prio_i(dbg_p),
    .ns_bit_i(ns), .reg_value_i(reg_value), .res_valid_o(res_valid),
    .do_access_o(do_acc), .undef_o(undef), .trap_hyp64_o(th64), .trap_hyp32_o(th32),
    .trap_mon_o(tmon), .syndrome_o(synd), .target_el_o(tgt), .rdata_o(rdata),
    .reg_we_o(we), .reg_wdata_o(rwdata)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_cfg();
    hyp_en = 0; hyp_64 = 0; hyp_t1 = 0; mon_pr = 0; mon_64 = 0; mon_tc = 0;
    dbg_u = 0; dbg_p = 0; ns = 0;
    coproc = 4'd15; opc1 = 3'd4; crn = 4'd1; crm = 4'd1; opc2 = 3'd2;
  endtask

  // drive at negedge, result registered at next posedge, sampled at following negedge
  task automatic run_req(input logic wr, input logic [1:0] el, input logic [4:0] exp_oh,
                         input logic [1:0] exp_tgt, input string tag);
    logic [5:0]  exp_syn;
    logic [31:0] exp_rd, exp_wd;
    logic        exp_we;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; cur_el = el;
    wdata = {16'hBEEF, 8'(n_checks), 8'h5A};
    exp_syn = (exp_oh & 5'b00111) != 0 ? 6'h03 : 6'h00;
    exp_we  = exp_oh[4] && wr;
    exp_rd  = (exp_oh[4] && !wr) ? reg_value : 32'h0;
    exp_wd  = exp_we ? wdata : 32'h0;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"},   64'(res_valid), 64'(1'b1));
    check({tag, " outcome"}, 64'({do_acc, undef, th64, th32, tmon}), 64'(exp_oh));
    check({tag, " syndrome"}, 64'(synd), 64'(exp_syn));
    check({tag, " target"},  64'(tgt), 64'(exp_tgt));
    check({tag, " we"},      64'(we), 64'(exp_we));
    check({tag, " rdata"},   64'(rdata), 64'(exp_rd));
    check({tag, " wdata"},   64'(rwdata), 64'(exp_wd));
  endtask

  task automatic expect_idle(input string tag);
    check({tag, " idle"}, 64'({res_valid, do_acc, undef, th64, th32, tmon, we, synd, tgt}), 64'(0));
    check({tag, " idle data"}, {rdata, rwdata}, 64'(0));
  endtask

  task automatic t_reset();
    @(negedge clk);
    expect_idle("R9 reset");
    // no stale outcome after a request
    clear_cfg(); ns = 1;
    run_req(1'b0, 2'd3, X_ACC, 2'd3, "R9 setup");
    @(negedge clk);
    expect_idle("R9 one cycle only");
  endtask

  task automatic t_encoding();
    clear_cfg(); ns = 1; cur_el = 2'd3;
    for (int f = 0; f < 5; f++) begin
      clear_cfg(); ns = 1;
      case (f)
        0: coproc = 4'd14;
        1: opc1 = 3'd5;
        2: crn = 4'd0;
        3: crm = 4'd2;
        default: opc2 = 3'd3;
      endcase
      @(negedge clk);
      req_valid = 1'b1; req_write = f[0];
      @(negedge clk);
      req_valid = 1'b0;
      expect_idle("R1 mismatch");
    end
    clear_cfg(); ns = 1;
    run_req(1'b1, 2'd3, X_ACC, 2'd3, "R1 match write");
  endtask

  task automatic t_el0();
    clear_cfg(); hyp_en = 1; hyp_t1 = 1; ns = 1;
    run_req(1'b0, 2'd0, X_UND, 2'd1, "R2 read");
    run_req(1'b1, 2'd0, X_UND, 2'd1, "R2 write");
  endtask

  task automatic t_el1();
    clear_cfg(); hyp_en = 1; hyp_t1 = 1; hyp_64 = 1;
    run_req(1'b0, 2'd1, X_H64, 2'd2, "R3 64-bit");
    hyp_64 = 0;
    run_req(1'b1, 2'd1, X_H32, 2'd2, "R3 32-bit");
    hyp_t1 = 0;
    run_req(1'b0, 2'd1, X_UND, 2'd1, "R4 t1 clear");
    hyp_t1 = 1; hyp_en = 0;
    run_req(1'b1, 2'd1, X_UND, 2'd1, "R4 hyp disabled");
  endtask

  task automatic t_el2();
    clear_cfg(); mon_pr = 1; mon_64 = 1; mon_tc = 1; dbg_p = 1; dbg_u = 0;
    run_req(1'b0, 2'd2, X_UND, 2'd2, "R5 prio cond clear");
    dbg_u = 1;
    run_req(1'b1, 2'd2, X_UND, 2'd2, "R5 prio cond set");
    dbg_p = 0; dbg_u = 1;
    run_req(1'b0, 2'd2, X_UND, 2'd2, "R6 cond undef");
    dbg_u = 0;
    run_req(1'b1, 2'd2, X_MON, 2'd3, "R6 monitor trap");
    mon_64 = 0; dbg_p = 1; dbg_u = 1;
    run_req(1'b0, 2'd2, X_ACC, 2'd2, "R7 32-bit monitor read");
    mon_64 = 1; mon_tc = 0;
    run_req(1'b1, 2'd2, X_ACC, 2'd2, "R7 trap bit clear write");
    mon_tc = 1; mon_pr = 0;
    run_req(1'b0, 2'd2, X_ACC, 2'd2, "R7 no monitor read");
  endtask

  task automatic t_el3();
    clear_cfg(); ns = 0;
    run_req(1'b0, 2'd3, X_UND, 2'd3, "R8 secure read");
    run_req(1'b1, 2'd3, X_UND, 2'd3, "R8 secure write");
    ns = 1;
    run_req(1'b0, 2'd3, X_ACC, 2'd3, "R8 nonsecure read");
  endtask

  task automatic t_write_path();
    clear_cfg(); ns = 1;
    reg_value = 32'h1234_5678;
    run_req(1'b0, 2'd3, X_ACC, 2'd3, "R10 read data");
    run_req(1'b1, 2'd3, X_ACC, 2'd3, "R10 write enable");
    ns = 0;
    run_req(1'b1, 2'd3, X_UND, 2'd3, "R10 no write on undef");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_encoding();
    t_el0();
    t_el1();
    t_el2();
    t_el3();
    t_write_path();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule